// File: doc/BRIEF.md
# Region-of-Interest Pixel Hit Filter

This block reduces the pixel data of a tracking detector one event at a time. Tracks are reconstructed elsewhere and extrapolated onto the pixel layers. Each extrapolation becomes a rectangular region of interest on one layer and module, centred on the track intercept and sized by the extrapolation uncertainty. Regions come from two sources. A fast pipelined source delivers them in event order. A slow processing farm finishes events in arbitrary order, so it sends its regions and a per-event accept or reject decision out of order.

An event is first opened in a pending table that holds up to eight events, indexed by the low bits of the event number. Regions from both sources are then gathered in the event's slot, which holds up to sixteen. The block does nothing further with the event until the slow decision arrives. For an accepted event it requests that event's hits from an external hit buffer. It tests each hit against the union of the stored regions and forwards only the hits that fall inside at least one region. It closes every event with a frame that carries the event number, the number of forwarded hits and the decision. A rejected event produces only the frame.

Top module: `roi_hit_filter`

## Requirements
- R1: After reset, hit_valid_o, frm_valid_o, rd_req_o and err_o are all low.
- R2: Regions for an open, undecided event are taken from both the fast and the slow region inputs, and filtering uses the union of both sets.
- R3: A hit matches a region when layer and module are equal and row_lo <= row <= row_hi and col_lo <= col <= col_hi, with all bounds inclusive. The region word is {layer[0], module[2:0], row_lo[9:0], row_hi[9:0], col_lo[7:0], col_hi[7:0]}, MSB first. The hit word is {layer[0], module[2:0], row[9:0], col[7:0], charge[7:0]}, MSB first.
- R4: A matching hit presented while an event is streaming appears unchanged on hit_o, with hit_valid_o high, one cycle after it is presented. Forwarded hits keep their input order. A hit that does not match is not forwarded.
- R5: rd_req_o is never raised for an event whose decision has not arrived, however many regions it holds.
- R6: Decisions may arrive in any event order. Each decision is matched to its pending event by the full event number.
- R7: A rejected event never raises rd_req_o. It emits one frame with frm_acc_o = 0 and frm_cnt_o = 0.
- R8: err_o pulses one cycle after one of two inputs: a decision whose event is not pending and undecided, or an open whose slot (event number modulo 8) is occupied. Such an input is otherwise ignored and produces no frame.
- R9: At most 16 regions per event are stored. Regions beyond that, from either source, have no effect on filtering.
- R10: One cycle after hit_end_i, an accepted event emits one frame with frm_evt_o equal to the event number, frm_cnt_o equal to the number of forwarded hits, and frm_acc_o = 1. rd_req_o is presented together with rd_evt_o equal to the event number.
- R11: A slot is released when its frame is emitted, and a new event number mapping to the same slot can then be opened and filtered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| open_valid_i | input | 1 | Register a new pending event |
| open_evt_i | input | 8 | Event number to register |
| fr_valid_i | input | 1 | Fast-source region valid |
| fr_evt_i | input | 8 | Event number of fast region |
| fr_roi_i | input | 40 | Fast-source region word |
| sr_roi_valid_i | input | 1 | Slow-source region valid |
| sr_roi_evt_i | input | 8 | Event number of slow region |
| sr_roi_i | input | 40 | Slow-source region word |
| dec_valid_i | input | 1 | Slow-source decision valid |
| dec_evt_i | input | 8 | Event number of decision |
| dec_acc_i | input | 1 | 1 = accept, 0 = reject |
| rd_req_o | output | 1 | One-cycle request for an event's hits |
| rd_evt_o | output | 8 | Event whose hits are requested |
| hit_valid_i | input | 1 | Buffered hit valid |
| hit_end_i | input | 1 | End of the requested event's hits |
| hit_i | input | 30 | Buffered hit word |
| hit_valid_o | output | 1 | Forwarded hit valid |
| hit_o | output | 30 | Forwarded hit word |
| frm_valid_o | output | 1 | Event frame valid |
| frm_evt_o | output | 8 | Frame event number |
| frm_cnt_o | output | 16 | Forwarded hit count |
| frm_acc_o | output | 1 | Frame decision |
| err_o | output | 1 | Ignored decision or open |

## Verification
Each accepted event is swept over a full 16 by 16 grid of rows and columns on two layers and two modules. Every hit of the sweep is compared with a containment test computed in the bench. The region shapes include single-pixel corners, full-width strips and regions that differ from their neighbours only in layer or module, so the sweep separates off-by-one bound errors and missing layer or module compares. Another event holds regions from both sources on separate modules, which shows whether the union is taken. A seventeenth region and a later slow region on an event that is already full cover the capacity limit. Decisions arrive out of order, for unknown events and for mismatched numbers that share a slot, to separate slot matching from full event-number matching.

// File: rtl/rhf_pkg.sv
package rhf_pkg;
  localparam int LAYER_W = 1;
  localparam int MOD_W   = 3;
  localparam int ROW_W   = 10;
  localparam int COL_W   = 8;
  localparam int CHG_W   = 8;

  typedef struct packed {
    logic [LAYER_W-1:0] layer;
    logic [MOD_W-1:0]   mod;
    logic [ROW_W-1:0]   row_lo;
    logic [ROW_W-1:0]   row_hi;
    logic [COL_W-1:0]   col_lo;
    logic [COL_W-1:0]   col_hi;
  } roi_t;

  typedef struct packed {
    logic [LAYER_W-1:0] layer;
    logic [MOD_W-1:0]   mod;
    logic [ROW_W-1:0]   row;
    logic [COL_W-1:0]   col;
    logic [CHG_W-1:0]   charge;
  } hit_t;

  localparam int ROI_W = $bits(roi_t);
  localparam int HIT_W = $bits(hit_t);
endpackage

// File: rtl/rhf_evt_table.sv
module rhf_evt_table #(
  parameter int NSLOT = 8,
  parameter int EVT_W = 8,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_valid_i,
  input  logic [EVT_W-1:0]  open_evt_i,
  input  logic              fr_valid_i,
  input  logic [EVT_W-1:0]  fr_evt_i,
  input  logic              sr_valid_i,
  input  logic [EVT_W-1:0]  sr_evt_i,
  input  logic              dec_valid_i,
  input  logic [EVT_W-1:0]  dec_evt_i,
  input  logic              dec_acc_i,
  input  logic              free_i,
  input  logic [SLOT_W-1:0] free_slot_i,
  output logic              open_wen_o,
  output logic              fr_wen_o,
  output logic              sr_wen_o,
  output logic [NSLOT-1:0]  ready_o,
  output logic [NSLOT-1:0]  acc_o,
  output logic [EVT_W-1:0]  evt_o [NSLOT],
  output logic              err_o
);
  logic [NSLOT-1:0] vld_q, dec_q, acc_q;
  logic [EVT_W-1:0] evt_q [NSLOT];
  logic [SLOT_W-1:0] os, fs, ss, ds;
  logic dec_ok;

  assign os = open_evt_i[SLOT_W-1:0];
  assign fs = fr_evt_i[SLOT_W-1:0];
  assign ss = sr_evt_i[SLOT_W-1:0];
  assign ds = dec_evt_i[SLOT_W-1:0];

  // a slot is live while opened, number matches and no decision yet
  assign open_wen_o = open_valid_i && !vld_q[os];
  assign fr_wen_o   = fr_valid_i && vld_q[fs] && !dec_q[fs] && (evt_q[fs] == fr_evt_i);
  assign sr_wen_o   = sr_valid_i && vld_q[ss] && !dec_q[ss] && (evt_q[ss] == sr_evt_i);
  assign dec_ok     = dec_valid_i && vld_q[ds] && !dec_q[ds] && (evt_q[ds] == dec_evt_i);

  assign ready_o = vld_q & dec_q;
  assign acc_o   = acc_q;
  assign evt_o   = evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      dec_q <= '0;
      acc_q <= '0;
      err_o <= 1'b0;
      for (int s = 0; s < NSLOT; s++) evt_q[s] <= '0;
    end else begin
      err_o <= (open_valid_i && !open_wen_o) || (dec_valid_i && !dec_ok);
      for (int s = 0; s < NSLOT; s++) begin
        if (free_i && free_slot_i == SLOT_W'(s)) begin
          vld_q[s] <= 1'b0;
          dec_q[s] <= 1'b0;
        end
        if (open_wen_o && os == SLOT_W'(s)) begin
          vld_q[s] <= 1'b1;
          dec_q[s] <= 1'b0;
          evt_q[s] <= open_evt_i;
        end
        if (dec_ok && ds == SLOT_W'(s)) begin
          dec_q[s] <= 1'b1;
          acc_q[s] <= dec_acc_i;
        end
      end
    end
  end

  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(open_valid_i || dec_valid_i));

  p_dec_needs_open_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_ok |=> dec_q[$past(ds)] && vld_q[$past(ds)]);
endmodule

// File: rtl/rhf_roi_store.sv
module rhf_roi_store import rhf_pkg::*; #(
  parameter int NSLOT = 8,
  parameter int NROI  = 16,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int CNT_W  = $clog2(NROI + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [SLOT_W-1:0] clr_slot_i,
  input  logic              fr_wen_i,
  input  logic [SLOT_W-1:0] fr_slot_i,
  input  roi_t              fr_roi_i,
  input  logic              sr_wen_i,
  input  logic [SLOT_W-1:0] sr_slot_i,
  input  roi_t              sr_roi_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output roi_t              rd_roi_o  [NROI],
  output logic [NROI-1:0]   rd_mask_o
);
  roi_t             mem_q [NSLOT][NROI];
  logic [CNT_W-1:0] cnt_q [NSLOT];
  logic [CNT_W-1:0] rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSLOT; s++) cnt_q[s] <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        logic f, g;
        logic [CNT_W:0] nxt;
        f = fr_wen_i && fr_slot_i == SLOT_W'(s);
        g = sr_wen_i && sr_slot_i == SLOT_W'(s);
        nxt = {1'b0, cnt_q[s]} + (CNT_W+1)'(f) + (CNT_W+1)'(g);
        if (clr_i && clr_slot_i == SLOT_W'(s)) cnt_q[s] <= '0;
        else if (nxt > (CNT_W+1)'(NROI)) cnt_q[s] <= CNT_W'(NROI);
        else cnt_q[s] <= nxt[CNT_W-1:0];
      end
    end
  end

  // fast region takes the lower index when both sources hit one slot
  always_ff @(posedge clk_i) begin
    for (int s = 0; s < NSLOT; s++) begin
      logic f;
      logic [CNT_W:0] si;
      f  = fr_wen_i && fr_slot_i == SLOT_W'(s);
      si = {1'b0, cnt_q[s]} + (CNT_W+1)'(f);
      for (int k = 0; k < NROI; k++) begin
        if (f && cnt_q[s] == CNT_W'(k)) mem_q[s][k] <= fr_roi_i;
        if (sr_wen_i && sr_slot_i == SLOT_W'(s) && si == (CNT_W+1)'(k)) mem_q[s][k] <= sr_roi_i;
      end
    end
  end

  assign rd_cnt = cnt_q[rd_slot_i];

  for (genvar k = 0; k < NROI; k++) begin : g_rd
    assign rd_roi_o[k]  = mem_q[rd_slot_i][k];
    assign rd_mask_o[k] = rd_cnt > CNT_W'(k);
  end

  p_cnt_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt <= CNT_W'(NROI));

  p_full_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cnt == CNT_W'(NROI) && !clr_i) |=> cnt_q[$past(rd_slot_i)] == CNT_W'(NROI));
endmodule

// File: rtl/rhf_match.sv
module rhf_match import rhf_pkg::*; #(
  parameter int NROI = 16
) (
  input  roi_t            roi_i  [NROI],
  input  logic [NROI-1:0] mask_i,
  input  hit_t            hit_i,
  output logic            match_o
);
  logic [NROI-1:0] in_roi;

  for (genvar k = 0; k < NROI; k++) begin : g_cmp
    assign in_roi[k] = mask_i[k]
                    && roi_i[k].layer == hit_i.layer
                    && roi_i[k].mod   == hit_i.mod
                    && hit_i.row >= roi_i[k].row_lo && hit_i.row <= roi_i[k].row_hi
                    && hit_i.col >= roi_i[k].col_lo && hit_i.col <= roi_i[k].col_hi;
  end

  assign match_o = |in_roi;
endmodule

// File: rtl/roi_hit_filter.sv
module roi_hit_filter import rhf_pkg::*; #(
  parameter int NSLOT = 8,
  parameter int NROI  = 16,
  parameter int EVT_W = 8,
  parameter int CNT_W = 16,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_valid_i,
  input  logic [EVT_W-1:0] open_evt_i,
  input  logic             fr_valid_i,
  input  logic [EVT_W-1:0] fr_evt_i,
  input  logic [ROI_W-1:0] fr_roi_i,
  input  logic             sr_roi_valid_i,
  input  logic [EVT_W-1:0] sr_roi_evt_i,
  input  logic [ROI_W-1:0] sr_roi_i,
  input  logic             dec_valid_i,
  input  logic [EVT_W-1:0] dec_evt_i,
  input  logic             dec_acc_i,
  output logic             rd_req_o,
  output logic [EVT_W-1:0] rd_evt_o,
  input  logic             hit_valid_i,
  input  logic             hit_end_i,
  input  logic [HIT_W-1:0] hit_i,
  output logic             hit_valid_o,
  output logic [HIT_W-1:0] hit_o,
  output logic             frm_valid_o,
  output logic [EVT_W-1:0] frm_evt_o,
  output logic [CNT_W-1:0] frm_cnt_o,
  output logic             frm_acc_o,
  output logic             err_o
);
  typedef enum logic {S_IDLE, S_STREAM} st_t;

  st_t               st_q;
  logic [SLOT_W-1:0] cur_q, pick, free_slot;
  logic              pick_any, free_now;
  logic              open_wen, fr_wen, sr_wen, match;
  logic [NSLOT-1:0]  ready, acc;
  logic [EVT_W-1:0]  slot_evt [NSLOT];
  logic [CNT_W-1:0]  fcnt_q;
  roi_t              rois [NROI];
  logic [NROI-1:0]   mask;

  rhf_evt_table #(.NSLOT(NSLOT), .EVT_W(EVT_W)) u_tab (
    .clk_i, .rst_ni,
    .open_valid_i, .open_evt_i,
    .fr_valid_i, .fr_evt_i,
    .sr_valid_i (sr_roi_valid_i), .sr_evt_i (sr_roi_evt_i),
    .dec_valid_i, .dec_evt_i, .dec_acc_i,
    .free_i (free_now), .free_slot_i (free_slot),
    .open_wen_o (open_wen), .fr_wen_o (fr_wen), .sr_wen_o (sr_wen),
    .ready_o (ready), .acc_o (acc), .evt_o (slot_evt),
    .err_o
  );

  rhf_roi_store #(.NSLOT(NSLOT), .NROI(NROI)) u_store (
    .clk_i, .rst_ni,
    .clr_i (open_wen), .clr_slot_i (open_evt_i[SLOT_W-1:0]),
    .fr_wen_i (fr_wen), .fr_slot_i (fr_evt_i[SLOT_W-1:0]), .fr_roi_i (roi_t'(fr_roi_i)),
    .sr_wen_i (sr_wen), .sr_slot_i (sr_roi_evt_i[SLOT_W-1:0]), .sr_roi_i (roi_t'(sr_roi_i)),
    .rd_slot_i (cur_q), .rd_roi_o (rois), .rd_mask_o (mask)
  );

  rhf_match #(.NROI(NROI)) u_match (
    .roi_i (rois), .mask_i (mask), .hit_i (hit_t'(hit_i)), .match_o (match)
  );

  // lowest decided slot first
  always_comb begin
    pick     = '0;
    pick_any = 1'b0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (ready[s]) begin
        pick     = SLOT_W'(s);
        pick_any = 1'b1;
      end
    end
  end

  assign free_now  = (st_q == S_IDLE && pick_any && !acc[pick]) || (st_q == S_STREAM && hit_end_i);
  assign free_slot = (st_q == S_IDLE) ? pick : cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      cur_q       <= '0;
      fcnt_q      <= '0;
      rd_req_o    <= 1'b0;
      rd_evt_o    <= '0;
      hit_valid_o <= 1'b0;
      hit_o       <= '0;
      frm_valid_o <= 1'b0;
      frm_evt_o   <= '0;
      frm_cnt_o   <= '0;
      frm_acc_o   <= 1'b0;
    end else begin
      rd_req_o    <= 1'b0;
      hit_valid_o <= 1'b0;
      frm_valid_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (pick_any) begin
          cur_q <= pick;
          if (acc[pick]) begin
            rd_req_o <= 1'b1;
            rd_evt_o <= slot_evt[pick];
            fcnt_q   <= '0;
            st_q     <= S_STREAM;
          end else begin
            frm_valid_o <= 1'b1;
            frm_evt_o   <= slot_evt[pick];
            frm_cnt_o   <= '0;
            frm_acc_o   <= 1'b0;
          end
        end
        S_STREAM: begin
          if (hit_end_i) begin
            frm_valid_o <= 1'b1;
            frm_evt_o   <= slot_evt[cur_q];
            frm_cnt_o   <= fcnt_q;
            frm_acc_o   <= 1'b1;
            st_q        <= S_IDLE;
          end else if (hit_valid_i) begin
            hit_valid_o <= match;
            hit_o       <= hit_i;
            fcnt_q      <= fcnt_q + CNT_W'(match);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_req_only_decided_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> ready[cur_q] && acc[cur_q]);

  p_hit_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> $past(hit_valid_i) && $past(st_q == S_STREAM) && hit_o == $past(hit_i));

  p_frame_after_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_o && frm_acc_o) |-> $past(hit_end_i));

  p_reject_no_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_o && !frm_acc_o) |-> !rd_req_o && frm_cnt_o == '0 && $past(st_q == S_IDLE));
endmodule

// File: tb/tb_roi_hit_filter.sv
module tb_roi_hit_filter;
  import rhf_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             open_valid = 0, fr_valid = 0, sr_valid = 0, dec_valid = 0, dec_acc = 0;
  logic [7:0]       open_evt = 0, fr_evt = 0, sr_evt = 0, dec_evt = 0;
  logic [ROI_W-1:0] fr_roi = 0, sr_roi = 0;
  logic             hit_valid = 0, hit_end = 0;
  logic [HIT_W-1:0] hit_in = 0;
  logic             rd_req_o, hit_valid_o, frm_valid_o, frm_acc_o, err_o;
  logic [7:0]       rd_evt_o, frm_evt_o;
  logic [HIT_W-1:0] hit_o;
  logic [15:0]      frm_cnt_o;

  roi_hit_filter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .open_valid_i(open_valid), .open_evt_i(open_evt),
    .fr_valid_i(fr_valid), .fr_evt_i(fr_evt), .fr_roi_i(fr_roi),
    .sr_roi_valid_i(sr_valid), .sr_roi_evt_i(sr_evt), .sr_roi_i(sr_roi),
    .dec_valid_i(dec_valid), .dec_evt_i(dec_evt), .dec_acc_i(dec_acc),
    .rd_req_o, .rd_evt_o,
    .hit_valid_i(hit_valid), .hit_end_i(hit_end), .hit_i(hit_in),
    .hit_valid_o, .hit_o,
    .frm_valid_o, .frm_evt_o, .frm_cnt_o, .frm_acc_o,
    .err_o
  );

  int n_chk = 0, n_fail = 0, n_frm = 0, n_req = 0;
  roi_t b_roi [8][32];
  int   b_n [8];
  logic [HIT_W-1:0] exp_hit [4096];
  int hw = 0, hr = 0;
  logic [7:0]  xf_evt;
  logic [15:0] xf_cnt;
  logic        xf_acc, xf_on = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic roi_t mk(input int l, input int m, input int rl, input int rh, input int cl, input int ch);
    roi_t r;
    r.layer = LAYER_W'(l); r.mod = MOD_W'(m);
    r.row_lo = ROW_W'(rl); r.row_hi = ROW_W'(rh);
    r.col_lo = COL_W'(cl); r.col_hi = COL_W'(ch);
    return r;
  endfunction

  // reference containment over the first 16 regions (R3, R9)
  function automatic bit ref_in(input int s, input hit_t h);
    int lim;
    lim = (b_n[s] < 16) ? b_n[s] : 16;
    for (int k = 0; k < lim; k++) begin
      roi_t r;
      r = b_roi[s][k];
      if (r.layer == h.layer && r.mod == h.mod &&
          int'(h.row) >= int'(r.row_lo) && int'(h.row) <= int'(r.row_hi) &&
          int'(h.col) >= int'(r.col_lo) && int'(h.col) <= int'(r.col_hi)) return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (hit_valid_o) begin
      if (hr < hw) chk(hit_o == exp_hit[hr], "R4 forwarded hit", 32'(hit_o), 32'(exp_hit[hr]));
      else chk(1'b0, "R4 unexpected hit", 32'(hit_o), 32'h0);
      hr++;
    end
    if (frm_valid_o) begin
      n_frm++;
      chk(xf_on, "R10 unexpected frame", 32'(frm_evt_o), 32'(xf_evt));
      chk(frm_evt_o == xf_evt, "R10 frame event", 32'(frm_evt_o), 32'(xf_evt));
      chk(frm_cnt_o == xf_cnt, "R10 frame count", 32'(frm_cnt_o), 32'(xf_cnt));
      chk(frm_acc_o == xf_acc, "R7 frame decision", 32'(frm_acc_o), 32'(xf_acc));
      xf_on = 0;
    end
    if (rd_req_o) n_req++;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic open_ev(input int e, input bit x_err);
    open_valid = 1; open_evt = 8'(e);
    tick();
    open_valid = 0;
    if (!x_err) b_n[e % 8] = 0;
    @(negedge clk);
    chk(err_o == x_err, "R8 open error flag", 32'(err_o), 32'(x_err));
  endtask

  task automatic add_roi(input bit slow, input int e, input roi_t r);
    if (slow) begin sr_valid = 1; sr_evt = 8'(e); sr_roi = r; end
    else begin fr_valid = 1; fr_evt = 8'(e); fr_roi = r; end
    tick();
    sr_valid = 0; fr_valid = 0;
    b_roi[e % 8][b_n[e % 8]] = r;
    b_n[e % 8]++;
  endtask

  task automatic decide(input int e, input bit a, input bit x_err);
    dec_valid = 1; dec_evt = 8'(e); dec_acc = a;
    tick();
    dec_valid = 0;
    @(negedge clk);
    chk(err_o == x_err, "R8 decision error flag", 32'(err_o), 32'(x_err));
  endtask

  task automatic wait_frames(input int target);
    for (int i = 0; i < 200 && n_frm < target; i++) @(negedge clk);
    chk(n_frm == target, "R10 frame arrival", 32'(n_frm), 32'(target));
  endtask

  task automatic run_accept(input int e);
    int s, cnt, f0;
    bit seen;
    s = e % 8; cnt = 0; f0 = n_frm; seen = 0;
    for (int i = 0; i < 50 && !seen; i++) begin
      @(negedge clk);
      if (rd_req_o) seen = 1;
    end
    chk(seen, "R10 read request", 32'(seen), 32'h1);
    chk(rd_evt_o == 8'(e), "R10 read event", 32'(rd_evt_o), 32'(e));
    for (int l = 0; l < 2; l++)
      for (int m = 1; m < 3; m++)
        for (int r = 0; r < 16; r++)
          for (int c = 0; c < 16; c++) begin
            hit_t h;
            h.layer = LAYER_W'(l); h.mod = MOD_W'(m);
            h.row = ROW_W'(r); h.col = COL_W'(c); h.charge = CHG_W'(r * 16 + c);
            hit_valid = 1; hit_in = h;
            if (ref_in(s, h)) begin exp_hit[hw] = h; hw++; cnt++; end
            @(posedge clk); #1;
          end
    hit_valid = 0;
    xf_evt = 8'(e); xf_cnt = 16'(cnt); xf_acc = 1; xf_on = 1;
    hit_end = 1;
    tick();
    hit_end = 0;
    wait_frames(f0 + 1);
    chk(hr == hw, "R4 all matching hits forwarded", 32'(hr), 32'(hw));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int req0;
    for (int s = 0; s < 8; s++) b_n[s] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!hit_valid_o && !frm_valid_o && !rd_req_o && !err_o, "R1 reset outputs",
        {28'h0, hit_valid_o, frm_valid_o, rd_req_o, err_o}, 32'h0);

    open_ev(5, 0); open_ev(6, 0); open_ev(7, 0);
    // R2: event 5 has fast and slow regions on separate modules
    add_roi(0, 5, mk(0, 1, 2, 5, 3, 6));
    add_roi(1, 5, mk(0, 2, 10, 12, 0, 1));
    add_roi(1, 5, mk(1, 1, 4, 4, 4, 9));
    // R3: corner pixel and full-width strip
    add_roi(0, 6, mk(0, 1, 0, 0, 15, 15));
    add_roi(0, 6, mk(1, 2, 7, 9, 0, 15));
    add_roi(1, 6, mk(0, 2, 15, 15, 0, 0));
    add_roi(0, 7, mk(0, 1, 0, 15, 0, 15));

    repeat (20) @(negedge clk);
    chk(n_req == 0, "R5 no read before decision", 32'(n_req), 32'h0);
    chk(n_frm == 0, "R5 no frame before decision", 32'(n_frm), 32'h0);

    decide(6, 1, 0);            // R6 out of order
    run_accept(6);

    req0 = n_req;
    xf_evt = 8'd7; xf_cnt = 0; xf_acc = 0; xf_on = 1;
    decide(7, 0, 0);
    wait_frames(2);
    chk(n_req == req0, "R7 reject issues no read", 32'(n_req), 32'(req0));

    decide(20, 1, 1);           // R8 unknown event
    decide(13, 1, 1);           // R8 same slot, other number
    repeat (10) @(negedge clk);
    chk(n_frm == 2 && n_req == req0, "R8 ignored decisions", 32'(n_frm), 32'h2);

    decide(5, 1, 0);
    run_accept(5);

    // R11 slot 5 reused; R9 capacity
    open_ev(13, 0);
    for (int k = 0; k < 16; k++) add_roi(0, 13, mk(0, 1, k, k, k, k));
    add_roi(0, 13, mk(0, 2, 0, 15, 0, 15));
    add_roi(1, 13, mk(1, 1, 0, 15, 0, 15));
    open_ev(22, 0);
    open_ev(30, 1);             // R8 slot 6 occupied
    decide(13, 1, 0);
    run_accept(13);
    chk(frm_cnt_o == 16'd16, "R9 only 16 regions used", 32'(frm_cnt_o), 32'd16);
    decide(13, 1, 1);           // R11 released slot no longer pending

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule